// File: doc/BRIEF.md
# Printer Port Register Interface

This block is the register side of a standard byte-wide printer port, reached through a small memory-mapped bus. A host writes an output byte, reads back status and programs a control byte. An internal printer model answers the host's strobe sequence. Raising the strobe bit sends the held output byte to the device side as a one-cycle pulse. Each status read then steps the model through its acknowledge and ready phases, so a polling driver sees a full handshake without a printer attached.

The device side has two parts. One is a byte output with a send pulse. The other is a byte input latch that the device loads with a load strobe. The control byte chooses which of the two bytes a data read returns. An interrupt request becomes pending when the strobe is dropped with interrupts enabled. A status read clears it.

Top module: `prn_port_regs`

## Requirements
- R1: After reset, a data read returns 0xFF, a status read returns 0xD9 and a control read returns 0xCC. The interrupt output and the send pulse are 0.
- R2: The address is 3 bits wide. Offset 0 is data, offset 1 is status and offset 2 is control. Reads at offsets 3 to 7 return 0xFF. Writes at offsets 1 and 3 to 7 change no register.
- R3: Every control write is stored with bits 7 and 6 set to 1. A control read returns the stored value.
- R4: A control write with bit 2 (init) equal to 0 sets the status to 0xD8.
- R5: A control write with bit 2, bit 3 (select) and bit 0 (strobe) all 1 clears status bit 7 (not-busy). If the stored strobe bit was 0 before the write, `dev_tx_send` is 1 for exactly one cycle, starting the cycle after the write. During that cycle `dev_tx_data` holds the last written data byte.
- R6: A control write with strobe 1 when the stored strobe bit is already 1 produces no send pulse.
- R7: A control write with bits 2 and 3 equal to 1 and bit 0 equal to 0 sets interrupt-pending if stored control bit 4 (IRQ enable) was 1 before the write. `irq_out` follows the pending flag from the cycle after the write.
- R8: A status read clears interrupt-pending. `irq_out` is 0 from the cycle after the read.
- R9: A status read returns the status as it was before the read. If status bit 7 and control bit 0 are both 0, the read then advances the model. When status bit 6 (ack) is 1, the read clears it. Otherwise the read sets bits 6 and 7.
- R10: A data read returns the device input latch when control bit 5 (direction) is 1, and the last written data byte when it is 0. A pulse on `dev_rx_load` loads `dev_rx_data` into the input latch.
- R11: A control write with bit 2 equal to 1 and bit 3 equal to 0 leaves the status and the pending flag unchanged and produces no send pulse.
- R12: `bus_rdata` is registered and is valid in the cycle after `bus_rd`. If `bus_wr` and `bus_rd` are both 1 in the same cycle, the write is performed and the read is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_out | output | 1 | Interrupt request |
| dev_tx_data | output | DATA_W | Byte sent to the device |
| dev_tx_send | output | 1 | One-cycle send pulse |
| dev_rx_data | input | DATA_W | Byte from the device |
| dev_rx_load | input | 1 | Loads the input latch |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. Read data, the send pulse and the interrupt level all appear in the cycle after the strobe, and the send pulse is gone one cycle later. The bench drives strobes on the falling edge for one cycle and samples on the next falling edge. It checks the send pulse there and again one cycle later to confirm that the pulse is only one cycle wide. A sweep over all 256 control bytes, each followed by control, status and data reads, compares the results against a bench-side model of the requirements. Since the status reads in the sweep start from many different status and control states, the sweep also steps the handshake through its phases.

// File: rtl/prn_pkg.sv
package prn_pkg;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CTRL = 3'd2;

  // status bit positions
  localparam int ST_READY = 7;
  localparam int ST_ACK   = 6;
  // control bit positions
  localparam int CT_DIR   = 5;
  localparam int CT_IRQEN = 4;
  localparam int CT_SEL   = 3;
  localparam int CT_INIT  = 2;
  localparam int CT_STB   = 0;

  localparam logic [7:0] STAT_RST   = 8'hD9;
  localparam logic [7:0] STAT_IDLE  = 8'hD8;
  localparam logic [7:0] CTRL_RST   = 8'hCC;
  localparam logic [7:0] CTRL_FIXED = 8'hC0;
  localparam logic [7:0] OPEN_BUS   = 8'hFF;
endpackage

// File: rtl/prn_ctrl_reg.sv
module prn_ctrl_reg
  import prn_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ctrl,
  input  logic [7:0] wdata,
  output logic [7:0] ctrl_q,
  output logic       fire,
  output logic       clr_ready,
  output logic       force_idle,
  output logic       irq_set
);
  logic armed;

  assign armed      = wdata[CT_INIT] & wdata[CT_SEL];
  assign force_idle = wr_ctrl & ~wdata[CT_INIT];
  assign clr_ready  = wr_ctrl & armed & wdata[CT_STB];
  assign fire       = clr_ready & ~ctrl_q[CT_STB];
  assign irq_set    = wr_ctrl & armed & ~wdata[CT_STB] & ctrl_q[CT_IRQEN];

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= CTRL_RST;
    else if (wr_ctrl) ctrl_q <= wdata | CTRL_FIXED;
  end
endmodule

// File: rtl/prn_status_model.sv
module prn_status_model
  import prn_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       force_idle,
  input  logic       clr_ready,
  input  logic       rd_stat,
  input  logic       ctrl_stb,
  output logic [7:0] stat_q
);
  logic step;

  assign step = rd_stat & ~stat_q[ST_READY] & ~ctrl_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= STAT_RST;
    end else if (force_idle) begin
      stat_q <= STAT_IDLE;
    end else if (clr_ready) begin
      stat_q[ST_READY] <= 1'b0;
    end else if (step) begin
      if (stat_q[ST_ACK]) begin
        stat_q[ST_ACK] <= 1'b0;
      end else begin
        stat_q[ST_ACK]   <= 1'b1;
        stat_q[ST_READY] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/prn_irq_unit.sv
module prn_irq_unit (
  input  logic clk,
  input  logic rst,
  input  logic irq_set,
  input  logic irq_clr,
  input  logic reeval,
  output logic irq_out
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (irq_set)      pend_d = 1'b1;
    else if (irq_clr) pend_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      irq_out <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (reeval) irq_out <= pend_d;
    end
  end
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
  import prn_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out,
  output logic [DATA_W-1:0] dev_tx_data,
  output logic              dev_tx_send,
  input  logic [DATA_W-1:0] dev_rx_data,
  input  logic              dev_rx_load
);
  localparam int unsigned OFS_W = 3;
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [OFS_W-1:0]  ofs;
  logic              rd_en;
  logic              wr_data, wr_ctrl, rd_stat;
  logic [7:0]        ctrl_q, stat_q;
  logic              fire, clr_ready, force_idle, irq_set;
  logic [DATA_W-1:0] out_q, in_q, rd_mux;

  assign ofs     = OFS_W'(bus_addr);
  assign rd_en   = bus_rd & ~bus_wr;
  assign wr_data = bus_wr & (ofs == OFS_DATA);
  assign wr_ctrl = bus_wr & (ofs == OFS_CTRL);
  assign rd_stat = rd_en & (ofs == OFS_STAT);

  prn_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wdata(bus_wdata[7:0]),
    .ctrl_q(ctrl_q), .fire(fire), .clr_ready(clr_ready),
    .force_idle(force_idle), .irq_set(irq_set)
  );

  prn_status_model u_stat (
    .clk(clk), .rst(rst), .force_idle(force_idle), .clr_ready(clr_ready),
    .rd_stat(rd_stat), .ctrl_stb(ctrl_q[CT_STB]), .stat_q(stat_q)
  );

  prn_irq_unit u_irq (
    .clk(clk), .rst(rst), .irq_set(irq_set), .irq_clr(rd_stat),
    .reeval(wr_data | wr_ctrl | rd_stat), .irq_out(irq_out)
  );

  // output and input byte latches
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= ALL_ONES;
      in_q  <= ALL_ONES;
    end else begin
      if (wr_data)     out_q <= bus_wdata;
      if (dev_rx_load) in_q  <= dev_rx_data;
    end
  end

  // device send path
  always_ff @(posedge clk) begin
    if (rst) begin
      dev_tx_send <= 1'b0;
      dev_tx_data <= ALL_ONES;
    end else begin
      dev_tx_send <= fire;
      if (fire) dev_tx_data <= out_q;
    end
  end

  always_comb begin
    case (ofs)
      OFS_DATA: rd_mux = ctrl_q[CT_DIR] ? in_q : out_q;
      OFS_STAT: rd_mux = DATA_W'(stat_q);
      OFS_CTRL: rd_mux = DATA_W'(ctrl_q);
      default:  rd_mux = ALL_ONES;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/prn_port_checker.sv
module prn_port_checker #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_out,
  input logic              dev_tx_send
);
  assert_send_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    dev_tx_send |=> !dev_tx_send);

  assert_send_cause_R5: assert property (@(posedge clk) disable iff (rst)
    dev_tx_send |-> $past(bus_wr && bus_addr == 2 && bus_wdata[0] && bus_wdata[2] && bus_wdata[3]));

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> $past(bus_wr && bus_addr == 2 && !bus_wdata[0]));

  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_out) |-> $past(bus_rd && !bus_wr && bus_addr == 1));

  assert_ctrl_fixed_R3: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && !bus_wr && bus_addr == 2) |-> bus_rdata[7:6] == 2'b11);

  assert_unmapped_R2: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && !bus_wr && bus_addr >= 3) |-> bus_rdata == '1);

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(bus_rd) && !$past(rst)) |-> $stable(bus_rdata));
endmodule

bind prn_port_regs prn_port_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .dev_tx_send(dev_tx_send)
);

// File: tb/test_prn_port_regs.sv
module test_prn_port_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       irq_out, dev_tx_send, dev_rx_load = 1'b0;
  logic [7:0] dev_tx_data, dev_rx_data = '0;
  int total = 0, bad = 0;

  // bench model of the requirements
  logic [7:0] m_ctrl, m_stat, m_dw, m_din;
  logic       m_pend, m_fire;

  always #2 clk = ~clk;

  prn_port_regs i_prn_port_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
    .dev_tx_data(dev_tx_data), .dev_tx_send(dev_tx_send),
    .dev_rx_data(dev_rx_data), .dev_rx_load(dev_rx_load)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic model_ctrl(input logic [7:0] v);
    m_fire = 1'b0;
    if (!v[2]) m_stat = 8'hD8;
    else if (v[3]) begin
      if (v[0]) begin
        m_stat[7] = 1'b0;
        m_fire = !m_ctrl[0];
      end else if (m_ctrl[4]) m_pend = 1'b1;
    end
    m_ctrl = v | 8'hC0;
  endtask

  task automatic model_stat_read();
    m_pend = 1'b0;
    if (!m_stat[7] && !m_ctrl[0]) begin
      if (m_stat[6]) m_stat[6] = 1'b0;
      else m_stat = m_stat | 8'hC0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq", int'(irq_out), 0);
    chk("R1 send", int'(dev_tx_send), 0);
    rd(3'd0, v); chk("R1 data", v, 8'hFF);
    rd(3'd2, v); chk("R1 ctrl", v, 8'hCC);
    rd(3'd1, v); chk("R1 stat", v, 8'hD9);
    m_ctrl = 8'hCC; m_stat = 8'hD9; m_dw = 8'hFF; m_din = 8'hFF; m_pend = 1'b0;

    // R2 unmapped offsets and ignored writes
    for (int a = 3; a < 8; a++) begin
      rd(3'(a), v); chk("R2 unmapped read", v, 8'hFF);
    end
    wr(3'd1, 8'h00); wr(3'd3, 8'h00); wr(3'd7, 8'h00);
    rd(3'd1, v); chk("R2 status after ignored write", v, m_stat);
    rd(3'd2, v); chk("R2 ctrl after ignored write", v, m_ctrl);
    rd(3'd0, v); chk("R2 data after ignored write", v, m_dw);

    // R10 direction select and input latch
    @(negedge clk); dev_rx_data = 8'h3C; dev_rx_load = 1'b1;
    @(negedge clk); dev_rx_load = 1'b0; m_din = 8'h3C;
    wr(3'd0, 8'hA5); m_dw = 8'hA5;
    wr(3'd2, 8'h2C); model_ctrl(8'h2C);
    rd(3'd0, v); chk("R10 input latch", v, 8'h3C);
    wr(3'd2, 8'h0C); model_ctrl(8'h0C);
    rd(3'd0, v); chk("R10 output latch", v, 8'hA5);

    // R5/R6 strobe rise sends once, held strobe does not
    wr(3'd2, 8'h0D); model_ctrl(8'h0D);
    chk("R5 send pulse", int'(dev_tx_send), 1);
    chk("R5 send byte", dev_tx_data, 8'hA5);
    @(negedge clk); chk("R5 pulse width", int'(dev_tx_send), 0);
    wr(3'd2, 8'h0D); model_ctrl(8'h0D);
    chk("R6 no second send", int'(dev_tx_send), 0);
    rd(3'd1, v); chk("R5 not-busy cleared", v, m_stat); model_stat_read();

    // R9 handshake: drop strobe, poll status
    wr(3'd2, 8'h0C); model_ctrl(8'h0C);
    for (int i = 0; i < 4; i++) begin
      rd(3'd1, v); chk("R9 handshake step", v, m_stat); model_stat_read();
    end

    // R7/R8 interrupt
    wr(3'd2, 8'h1D); model_ctrl(8'h1D);
    wr(3'd2, 8'h1C); model_ctrl(8'h1C);
    chk("R7 irq raised", int'(irq_out), 1);
    wr(3'd0, 8'h11); m_dw = 8'h11;
    chk("R7 irq held over data write", int'(irq_out), 1);
    rd(3'd1, v); chk("R8 status value", v, m_stat); model_stat_read();
    chk("R8 irq cleared", int'(irq_out), 0);

    // R11 select low: nothing changes
    wr(3'd2, 8'h15); model_ctrl(8'h15);
    chk("R11 no send", int'(dev_tx_send), 0);
    chk("R11 no irq", int'(irq_out), 0);
    rd(3'd1, v); chk("R11 status kept", v, m_stat); model_stat_read();

    // R4 init low
    wr(3'd2, 8'h08); model_ctrl(8'h08);
    rd(3'd1, v); chk("R4 status idle", v, 8'hD8); model_stat_read();

    // R12 write wins over simultaneous read
    rd(3'd2, v);
    @(negedge clk); bus_addr = 3'd0; bus_wdata = 8'h77; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0; m_dw = 8'h77;
    chk("R12 rdata held", bus_rdata, v);
    rd(3'd0, v); chk("R12 write done", v, 8'h77);

    // sweep of every control byte with R3 store check
    for (int c = 0; c < 256; c++) begin
      wr(3'd0, 8'(c ^ 8'h5A)); m_dw = 8'(c ^ 8'h5A);
      wr(3'd2, 8'(c)); model_ctrl(8'(c));
      chk("R5 sweep send", int'(dev_tx_send), int'(m_fire));
      if (m_fire) chk("R5 sweep byte", dev_tx_data, m_dw);
      chk("R7 sweep irq", int'(irq_out), int'(m_pend));
      rd(3'd2, v); chk("R3 sweep ctrl", v, m_ctrl);
      rd(3'd1, v); chk("R9 sweep stat", v, m_stat); model_stat_read();
      chk("R8 sweep irq", int'(irq_out), 0);
      rd(3'd0, v); chk("R10 sweep data", v, m_ctrl[5] ? m_din : m_dw);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule